// File: doc/BRIEF.md
# Extended Register and Stack Transfer Unit

This block is the register slice of an 8-bit accumulator-style processor core. It holds the accumulator A, the index registers X and Y, a zero-page base register Z and a 16-bit stack pointer S. It also carries out a set of single-byte extended opcodes:

- copies between registers;
- swaps between registers;
- loading and reading the wide stack pointer through A and X;
- pushing or pulling A, X and Y together in one opcode, for fast task switching;
- a subroutine call through a pointer table indexed by X.

It also forms zero-page addresses by placing Z above an 8-bit offset, so the surrounding core can move zero page anywhere in the 64 KiB space.

Opcodes arrive on a valid/ready port. An opcode is taken on a clock edge where `op_valid` and `op_ready` are both high. `op_ready` is high only while no stack sequence is running. While `op_valid` is high and `op_ready` is low, the source must hold `op_code`, `op_operand` and `op_ret` stable.

Stack traffic uses a synchronous byte-wide memory port. Read data is expected on `mem_rdata` in the cycle after the cycle that drove `mem_re`. When an operation completes, `done` pulses for one cycle.

Top module: `regx_unit`

## Requirements
- R1: `op_ready` is high exactly when no stack sequence is in progress. `done` pulses for one cycle. After the acceptance edge, the cycle in which `done` is seen is: 1 for copies, swaps and unlisted opcodes; 4 for the three-register push; 5 for the three-register pull; 6 for the table call.
- R2: Opcode 0x1B copies A into Z. Opcode 0x3B copies Z into A. Opcode 0x9B copies X into Y. Opcode 0xBB copies Y into X. No other register changes.
- R3: Opcode 0xEB swaps X and Y. Opcode 0x0B swaps A and X. Opcode 0x2B swaps A and Y. Each swap completes in one operation.
- R4: Opcode 0x4B loads S with A as the high byte and X as the low byte. Opcode 0x5B puts the high byte of S into A and the low byte of S into X.
- R5: Opcode 0x8B writes A at address S, X at S-1 and Y at S-2, in that order, one byte per cycle. S ends 3 lower.
- R6: Opcode 0xAB reads address S+1 into Y, S+2 into X and S+3 into A. S ends 3 higher.
- R7: All stack pointer arithmetic wraps modulo 65536.
- R8: `zp_addr` equals Z in bits 15:8 and `zp_off` in bits 7:0.
- R9: Opcode 0xFC does the following in order:
  - writes `op_ret` bits 15:8 at S and bits 7:0 at S-1, leaving S 2 lower;
  - reads the pointer low byte at `op_operand`+X and the high byte at `op_operand`+X+1, with 16-bit wrap;
  - presents the pointer on `jmp_addr` while `done` is high.
- R10: Any other opcode is accepted and completes with `done`, and leaves A, X, Y, Z and S unchanged.
- R11: After reset, A, X, Y and Z are 0, S is 0x01FF, `op_ready` is 1, and `done`, `mem_we` and `mem_re` are 0.
- R12: `mem_we` and `mem_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode offered |
| op_ready | output | 1 | Unit can take an opcode |
| op_code | input | 8 | Opcode byte |
| op_operand | input | 16 | Pointer table base for the table call |
| op_ret | input | 16 | Return address pushed by the table call |
| zp_off | input | 8 | Zero-page offset |
| zp_addr | output | 16 | Relocated zero-page address |
| mem_addr | output | 16 | Stack memory address |
| mem_wdata | output | 8 | Stack memory write data |
| mem_we | output | 1 | Stack memory write enable |
| mem_re | output | 1 | Stack memory read enable |
| mem_rdata | input | 8 | Read data, one cycle after `mem_re` |
| done | output | 1 | Operation complete pulse |
| jmp_addr | output | 16 | Call target fetched by the table call |
| reg_a | output | 8 | Accumulator |
| reg_x | output | 8 | X index |
| reg_y | output | 8 | Y index |
| reg_z | output | 8 | Zero-page base |
| reg_s | output | 16 | Stack pointer |

## Verification
Most internal state is visible on the register outputs in the cycle after the edge that changes it. A faulty swap or copy path therefore shows at the first sample after `done`.

A wrong stack pointer step or byte index shows up in two places:
- right away, as a wrong `mem_addr` or `mem_wdata` during the sequence;
- afterwards, as a stack memory image or final `reg_s` that disagrees with the arithmetic model.

A mis-routed pull destination, or an off-by-one in the read pipeline, surfaces as swapped or stale register bytes when `done` rises. A wrong sequence length appears as a `done` latency that differs from the fixed count for that opcode.

// File: rtl/regx_pkg.sv
package regx_pkg;
  localparam logic [7:0] OPC_PUSH3  = 8'h8B;
  localparam logic [7:0] OPC_PULL3  = 8'hAB;
  localparam logic [7:0] OPC_A2Z    = 8'h1B;
  localparam logic [7:0] OPC_Z2A    = 8'h3B;
  localparam logic [7:0] OPC_X2Y    = 8'h9B;
  localparam logic [7:0] OPC_Y2X    = 8'hBB;
  localparam logic [7:0] OPC_SWPXY  = 8'hEB;
  localparam logic [7:0] OPC_SWPAX  = 8'h0B;
  localparam logic [7:0] OPC_SWPAY  = 8'h2B;
  localparam logic [7:0] OPC_SPLD   = 8'h4B;
  localparam logic [7:0] OPC_SPRD   = 8'h5B;
  localparam logic [7:0] OPC_CALLT  = 8'hFC;

  typedef enum logic [3:0] {
    K_NOP, K_PUSH3, K_PULL3, K_A2Z, K_Z2A, K_X2Y, K_Y2X,
    K_SWAP_XY, K_SWAP_AX, K_SWAP_AY, K_SP_LOAD, K_SP_READ, K_CALL_TBL
  } op_kind_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH, ST_PULL, ST_CALL, ST_DRAIN
  } seq_state_t;

  typedef enum logic [2:0] {
    DST_A, DST_X, DST_Y, DST_JLO, DST_JHI, DST_NONE
  } dst_t;

  typedef enum logic [1:0] {
    STEP_NONE, STEP_DEC, STEP_INC
  } s_step_t;
endpackage

// File: rtl/regx_decode.sv
module regx_decode
  import regx_pkg::*;
(
  input  logic [7:0] opcode,
  output op_kind_t   kind
);
  always_comb begin
    unique case (opcode)
      OPC_PUSH3: kind = K_PUSH3;
      OPC_PULL3: kind = K_PULL3;
      OPC_A2Z:   kind = K_A2Z;
      OPC_Z2A:   kind = K_Z2A;
      OPC_X2Y:   kind = K_X2Y;
      OPC_Y2X:   kind = K_Y2X;
      OPC_SWPXY: kind = K_SWAP_XY;
      OPC_SWPAX: kind = K_SWAP_AX;
      OPC_SWPAY: kind = K_SWAP_AY;
      OPC_SPLD:  kind = K_SP_LOAD;
      OPC_SPRD:  kind = K_SP_READ;
      OPC_CALLT: kind = K_CALL_TBL;
      default:   kind = K_NOP;
    endcase
  end
endmodule

// File: rtl/regx_regfile.sv
module regx_regfile
  import regx_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned S_RST = 'h01FF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            xfer_fire,
  input  op_kind_t        kind,
  input  logic            ld_en,
  input  dst_t            ld_dst,
  input  logic [DW-1:0]   ld_data,
  input  s_step_t         s_step,
  output logic [DW-1:0]   a,
  output logic [DW-1:0]   x,
  output logic [DW-1:0]   y,
  output logic [DW-1:0]   z,
  output logic [2*DW-1:0] s
);
  localparam int unsigned AW = 2 * DW;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a <= '0;
      x <= '0;
      y <= '0;
      z <= '0;
      s <= AW'(S_RST);
    end else begin
      if (xfer_fire) begin
        unique case (kind)
          K_A2Z:     z <= a;
          K_Z2A:     a <= z;
          K_X2Y:     y <= x;
          K_Y2X:     x <= y;
          K_SWAP_XY: begin x <= y; y <= x; end
          K_SWAP_AX: begin a <= x; x <= a; end
          K_SWAP_AY: begin a <= y; y <= a; end
          K_SP_LOAD: s <= {a, x};
          K_SP_READ: begin a <= s[AW-1:DW]; x <= s[DW-1:0]; end
          default:   ;
        endcase
      end
      if (ld_en) begin
        unique case (ld_dst)
          DST_A:   a <= ld_data;
          DST_X:   x <= ld_data;
          DST_Y:   y <= ld_data;
          default: ;
        endcase
      end
      unique case (s_step)
        STEP_DEC: s <= s - 1'b1;
        STEP_INC: s <= s + 1'b1;
        default:  ;
      endcase
    end
  end

  AST_SWAP_XY: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_fire && kind == K_SWAP_XY) |=> (x == $past(y) && y == $past(x))); // R3
  AST_A2Z_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_fire && kind == K_A2Z) |=> (z == $past(a) && a == $past(a))); // R2
  AST_SP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_fire && kind == K_SP_LOAD) |=> (s == {$past(a), $past(x)})); // R4
  AST_S_DEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (s_step == STEP_DEC) |=> (s == AW'($past(s) - 1'b1))); // R7
  AST_S_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (s_step == STEP_INC) |=> (s == AW'($past(s) + 1'b1))); // R7
endmodule

// File: rtl/regx_stack_seq.sv
module regx_stack_seq
  import regx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  op_kind_t        kind,
  input  logic [2*DW-1:0] operand,
  input  logic [2*DW-1:0] ret_addr,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   x,
  input  logic [DW-1:0]   y,
  input  logic [2*DW-1:0] s,
  input  logic [DW-1:0]   mem_rdata,
  output logic            busy,
  output logic [2*DW-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_we,
  output logic            mem_re,
  output logic            ld_en,
  output dst_t            ld_dst,
  output logic [DW-1:0]   ld_data,
  output s_step_t         s_step,
  output logic            done,
  output logic [2*DW-1:0] jmp_addr
);
  localparam int unsigned AW = 2 * DW;

  seq_state_t      st;
  logic [1:0]      idx;
  logic [AW-1:0]   operand_q;
  logic [AW-1:0]   ret_q;
  logic            pend_q;
  dst_t            pend_dst_q;
  dst_t            issue_dst;
  logic [AW-1:0]   ptr_base;

  assign busy     = (st != ST_IDLE);
  assign ptr_base = operand_q + {{DW{1'b0}}, x};

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    s_step    = STEP_NONE;
    issue_dst = DST_NONE;
    unique case (st)
      ST_PUSH: begin
        mem_we   = 1'b1;
        mem_addr = s;
        s_step   = STEP_DEC;
        unique case (idx)
          2'd0:    mem_wdata = a;
          2'd1:    mem_wdata = x;
          default: mem_wdata = y;
        endcase
      end
      ST_PULL: begin
        mem_re   = 1'b1;
        mem_addr = s + 1'b1;
        s_step   = STEP_INC;
        unique case (idx)
          2'd0:    issue_dst = DST_Y;
          2'd1:    issue_dst = DST_X;
          default: issue_dst = DST_A;
        endcase
      end
      ST_CALL: begin
        unique case (idx)
          2'd0: begin
            mem_we    = 1'b1;
            mem_addr  = s;
            mem_wdata = ret_q[AW-1:DW];
            s_step    = STEP_DEC;
          end
          2'd1: begin
            mem_we    = 1'b1;
            mem_addr  = s;
            mem_wdata = ret_q[DW-1:0];
            s_step    = STEP_DEC;
          end
          2'd2: begin
            mem_re    = 1'b1;
            mem_addr  = ptr_base;
            issue_dst = DST_JLO;
          end
          default: begin
            mem_re    = 1'b1;
            mem_addr  = ptr_base + 1'b1;
            issue_dst = DST_JHI;
          end
        endcase
      end
      default: ;
    endcase
  end

  assign ld_en   = pend_q && (pend_dst_q == DST_A || pend_dst_q == DST_X ||
                              pend_dst_q == DST_Y);
  assign ld_dst  = pend_dst_q;
  assign ld_data = mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      idx        <= '0;
      operand_q  <= '0;
      ret_q      <= '0;
      pend_q     <= 1'b0;
      pend_dst_q <= DST_NONE;
      done       <= 1'b0;
      jmp_addr   <= '0;
    end else begin
      done       <= 1'b0;
      pend_q     <= mem_re;
      pend_dst_q <= issue_dst;
      if (pend_q && pend_dst_q == DST_JLO) jmp_addr[DW-1:0]  <= mem_rdata;
      if (pend_q && pend_dst_q == DST_JHI) jmp_addr[AW-1:DW] <= mem_rdata;
      unique case (st)
        ST_IDLE: begin
          idx <= '0;
          if (accept) begin
            unique case (kind)
              K_PUSH3:    st <= ST_PUSH;
              K_PULL3:    st <= ST_PULL;
              K_CALL_TBL: begin
                st        <= ST_CALL;
                operand_q <= operand;
                ret_q     <= ret_addr;
              end
              default:    done <= 1'b1;
            endcase
          end
        end
        ST_PUSH: begin
          idx <= idx + 2'd1;
          if (idx == 2'd2) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end
        end
        ST_PULL: begin
          idx <= idx + 2'd1;
          if (idx == 2'd2) st <= ST_DRAIN;
        end
        ST_CALL: begin
          idx <= idx + 2'd1;
          if (idx == 2'd3) st <= ST_DRAIN;
        end
        default: begin
          st   <= ST_IDLE;
          done <= 1'b1;
        end
      endcase
    end
  end

  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R12
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (st == ST_IDLE)); // R1
  AST_PUSH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PUSH && idx == 2'd2) |=> done); // R5
  AST_PULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PULL && idx == 2'd2) |=> (st == ST_DRAIN)); // R6
endmodule

// File: rtl/regx_unit.sv
module regx_unit
  import regx_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned S_RST = 'h01FF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic [7:0]      op_code,
  input  logic [2*DW-1:0] op_operand,
  input  logic [2*DW-1:0] op_ret,
  input  logic [DW-1:0]   zp_off,
  output logic [2*DW-1:0] zp_addr,
  output logic [2*DW-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_we,
  output logic            mem_re,
  input  logic [DW-1:0]   mem_rdata,
  output logic            done,
  output logic [2*DW-1:0] jmp_addr,
  output logic [DW-1:0]   reg_a,
  output logic [DW-1:0]   reg_x,
  output logic [DW-1:0]   reg_y,
  output logic [DW-1:0]   reg_z,
  output logic [2*DW-1:0] reg_s
);
  op_kind_t      kind;
  logic          busy;
  logic          accept;
  logic          ld_en;
  dst_t          ld_dst;
  logic [DW-1:0] ld_data;
  s_step_t       s_step;

  assign op_ready = !busy;
  assign accept   = op_valid && op_ready;
  assign zp_addr  = {reg_z, zp_off};

  regx_decode u_decode (
    .opcode (op_code),
    .kind   (kind)
  );

  regx_regfile #(.DW(DW), .S_RST(S_RST)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_fire (accept),
    .kind      (kind),
    .ld_en     (ld_en),
    .ld_dst    (ld_dst),
    .ld_data   (ld_data),
    .s_step    (s_step),
    .a         (reg_a),
    .x         (reg_x),
    .y         (reg_y),
    .z         (reg_z),
    .s         (reg_s)
  );

  regx_stack_seq #(.DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .kind      (kind),
    .operand   (op_operand),
    .ret_addr  (op_ret),
    .a         (reg_a),
    .x         (reg_x),
    .y         (reg_y),
    .s         (reg_s),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .ld_en     (ld_en),
    .ld_dst    (ld_dst),
    .ld_data   (ld_data),
    .s_step    (s_step),
    .done      (done),
    .jmp_addr  (jmp_addr)
  );

  AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == K_NOP) |=> (reg_a == $past(reg_a) && reg_x == $past(reg_x) &&
      reg_y == $past(reg_y) && reg_z == $past(reg_z) && reg_s == $past(reg_s))); // R10
  AST_BUSY_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (kind == K_PUSH3 || kind == K_PULL3 || kind == K_CALL_TBL)) |=> !op_ready); // R1
endmodule

// File: tb/regx_unit_bench.sv
`timescale 1ns/1ps
module regx_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [7:0]  op_code = 8'h00;
  logic [15:0] op_operand = 16'h0000;
  logic [15:0] op_ret = 16'h0000;
  logic [7:0]  zp_off = 8'h00;
  logic [15:0] zp_addr, mem_addr, jmp_addr, reg_s;
  logic [7:0]  mem_wdata, mem_rdata, reg_a, reg_x, reg_y, reg_z;
  logic        mem_we, mem_re, done;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [7:0] mem [logic [15:0]];
  logic [7:0] ea, ex, ey, ez, tmp;
  logic [15:0] es;
  logic [31:0] lcg = 32'h1234_5678;

  always #2 clk = ~clk;

  regx_unit u_regx_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_operand(op_operand), .op_ret(op_ret),
    .zp_off(zp_off), .zp_addr(zp_addr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .done(done), .jmp_addr(jmp_addr),
    .reg_a(reg_a), .reg_x(reg_x), .reg_y(reg_y), .reg_z(reg_z), .reg_s(reg_s)
  );

  function automatic logic [7:0] rdm(input logic [15:0] ad);
    if (mem.exists(ad)) return mem[ad];
    return ad[7:0] ^ ad[15:8] ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] = mem_wdata;
    if (mem_re) mem_rdata <= rdm(mem_addr);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      summary();
    end
  end

  always @(negedge clk) if (rst_n) chk("R12 port exclusive", {31'd0, mem_we & mem_re}, 32'd0);

  // Issue one opcode and report the cycle (after acceptance) where done is seen.
  task automatic do_op(input logic [7:0] opc, input logic [15:0] opr,
                       input logic [15:0] ret, input int exp_lat);
    int lat;
    @(negedge clk);
    op_valid = 1'b1; op_code = opc; op_operand = opr; op_ret = ret;
    while (!op_ready) @(negedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    lat = 1;
    if (exp_lat > 1) begin
      chk("R1 ready low while busy", {31'd0, op_ready}, 32'd0);
      chk("R1 no early done", {31'd0, done}, 32'd0);
    end
    while (!done && lat < 40) begin @(negedge clk); lat++; end
    chk("R1 done latency", lat, exp_lat);
  endtask

  task automatic chk_regs(input string req);
    chk({req, " A"}, reg_a, ea);
    chk({req, " X"}, reg_x, ex);
    chk({req, " Y"}, reg_y, ey);
    chk({req, " Z"}, reg_z, ez);
    chk({req, " S"}, reg_s, es);
  endtask

  task automatic pull3(input logic [7:0] v1, input logic [7:0] v2, input logic [7:0] v3);
    mem[es + 16'd1] = v1; mem[es + 16'd2] = v2; mem[es + 16'd3] = v3;
    do_op(8'hAB, 16'h0, 16'h0, 5);
    ey = v1; ex = v2; ea = v3; es = es + 16'd3;
    chk_regs("R6 pull");
  endtask

  task automatic push3(input string req);
    logic [15:0] s0;
    s0 = es;
    do_op(8'h8B, 16'h0, 16'h0, 4);
    es = es - 16'd3;
    chk({req, " byte A"}, rdm(s0), ea);
    chk({req, " byte X"}, rdm(s0 - 16'd1), ex);
    chk({req, " byte Y"}, rdm(s0 - 16'd2), ey);
    chk_regs(req);
  endtask

  function automatic logic [7:0] rnd8();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg[23:16];
  endfunction

  initial begin
    logic [7:0] nops [4];
    nops[0] = 8'h00; nops[1] = 8'hEA; nops[2] = 8'h4C; nops[3] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ea = 0; ex = 0; ey = 0; ez = 0; es = 16'h01FF;
    chk_regs("R11 reset");
    chk("R11 ready", {31'd0, op_ready}, 32'd1);
    chk("R11 done", {31'd0, done}, 32'd0);
    chk("R11 we", {31'd0, mem_we}, 32'd0);
    chk("R11 re", {31'd0, mem_re}, 32'd0);

    // R7 wrap: S = 0x0001, push crosses to 0xFFFF, pull crosses back
    pull3(8'h77, 8'h01, 8'h00);
    do_op(8'h4B, 16'h0, 16'h0, 1);
    es = {ea, ex};
    chk_regs("R4 load S");
    push3("R7 push wrap");
    chk("R7 S wrapped", reg_s, 16'hFFFE);
    pull3(rdm(16'hFFFF), rdm(16'h0000), rdm(16'h0001));
    chk("R7 pull wrap S", reg_s, 16'h0001);

    for (int i = 0; i < 40; i++) begin
      logic [15:0] opr, ret, p;
      pull3(rnd8(), rnd8(), rnd8());
      do_op(8'h1B, 16'h0, 16'h0, 1); ez = ea; chk_regs("R2 A to Z");
      zp_off = 8'(i * 37);
      #1 chk("R8 zp addr", zp_addr, {ez, zp_off});
      do_op(8'h0B, 16'h0, 16'h0, 1); tmp = ea; ea = ex; ex = tmp; chk_regs("R3 swap AX");
      do_op(8'h2B, 16'h0, 16'h0, 1); tmp = ea; ea = ey; ey = tmp; chk_regs("R3 swap AY");
      do_op(8'hEB, 16'h0, 16'h0, 1); tmp = ex; ex = ey; ey = tmp; chk_regs("R3 swap XY");
      do_op(8'h3B, 16'h0, 16'h0, 1); ea = ez; chk_regs("R2 Z to A");
      if (i % 2 == 0) begin
        do_op(8'h9B, 16'h0, 16'h0, 1); ey = ex; chk_regs("R2 X to Y");
      end else begin
        do_op(8'hBB, 16'h0, 16'h0, 1); ex = ey; chk_regs("R2 Y to X");
      end
      do_op(8'h5B, 16'h0, 16'h0, 1); ea = es[15:8]; ex = es[7:0]; chk_regs("R4 read S");
      do_op(8'h2B, 16'h0, 16'h0, 1); tmp = ea; ea = ey; ey = tmp; chk_regs("R3 swap AY");
      do_op(8'h4B, 16'h0, 16'h0, 1); es = {ea, ex}; chk_regs("R4 load S");
      do_op(nops[i % 4], 16'h0, 16'h0, 1); chk_regs("R10 unlisted opcode");
      push3("R5 push");
      opr = (i % 2 == 1) ? 16'hFFFF - 16'(i) : 16'h2000 + 16'(i * 7);
      ret = {rnd8(), rnd8()};
      p = opr + {8'h00, ex};
      do_op(8'hFC, opr, ret, 6);
      chk("R9 jmp target", jmp_addr, {rdm(p + 16'd1), rdm(p)});
      chk("R9 ret high", rdm(es), ret[15:8]);
      chk("R9 ret low", rdm(es - 16'd1), ret[7:0]);
      es = es - 16'd2;
      chk_regs("R9 call regs");
    end
    summary();
  end
endmodule